// File: doc/BRIEF.md
# Typed Reservation Station Array

This block holds the instructions waiting for their operands in front of five functional units: one integer ALU, one load unit, one store unit and two floating-point pipes. Each unit owns exactly one station. A station keeps the operation code, the reorder-buffer entry that will receive the result, and two operand slots. An operand slot holds either a value that is already known or the tag of the producer it is waiting for.

Instructions enter through a single dispatch port. The port carries the rename information for both sources: the tag from the map table, a "value already sits in the reorder buffer" flag, the register-file value and the reorder-buffer value. The station resolves each operand on entry. While a station waits, it watches the single result broadcast bus and captures any value whose tag it needs.

A station that is occupied and has no pending tags raises its ready line. Its contents show on the issue outputs. When the functional unit pulses that station's go input, execution begins and the station frees on the next edge. Because results are named by reorder-buffer entry and not by station, the station does not have to stay allocated until write-back. A flush empties the whole array.

Top module: `rs_array`

## Requirements
- R1: After a synchronous reset, every station reads not busy and not ready.
- R2: The station type code is ALU=0, LD=1, ST=2, FP1=3, FP2=4. A dispatch with a code for a free station occupies that station on the next edge, and the issue outputs then show its op and destination tag. A dispatch with a code of 5 to 7 is dropped and changes no station.
- R3: A dispatch whose station is busy raises the stall output in the same cycle and leaves that station's contents unchanged.
- R4: A source with rename tag 0 is stored as the register-file value supplied with the dispatch, with no pending tag.
- R5: A source with a nonzero tag and the ready-in-buffer flag set is stored as the reorder-buffer value supplied with the dispatch, with no pending tag.
- R6: A source with a nonzero tag and the flag clear keeps its tag, and the station is not ready.
- R7: A valid broadcast whose nonzero tag equals a pending source tag writes the broadcast value into that slot and clears the tag. A broadcast with any other tag leaves the station unchanged.
- R8: A broadcast that matches a pending source of the instruction being dispatched in the same cycle is captured.
- R9: A station is ready exactly when it is busy and neither source has a pending tag.
- R10: A go pulse on a ready station frees it on the next edge. A go pulse on a station that is not ready has no effect.
- R11: A flush frees every station on the next edge, and it overrides a dispatch in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Free every station |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 3 | Target station type code |
| disp_op | input | 4 | Operation code |
| disp_dst | input | 3 | Reorder-buffer entry of the result |
| src_a_tag | input | 3 | Rename tag of source A (0 = in register file) |
| src_a_inbuf | input | 1 | Source A value already in reorder buffer |
| src_a_rf | input | 32 | Register-file value of source A |
| src_a_buf | input | 32 | Reorder-buffer value of source A |
| src_b_tag | input | 3 | Rename tag of source B |
| src_b_inbuf | input | 1 | Source B value already in reorder buffer |
| src_b_rf | input | 32 | Register-file value of source B |
| src_b_buf | input | 32 | Reorder-buffer value of source B |
| bc_valid | input | 1 | Broadcast bus valid |
| bc_tag | input | 3 | Broadcast result tag |
| bc_val | input | 32 | Broadcast result value |
| issue_go | input | 5 | Per-station start-execution pulse |
| disp_stall | output | 1 | Target station busy, dispatch held |
| st_busy | output | 5 | Per-station occupied |
| st_ready | output | 5 | Per-station ready to issue |
| iss_op | output | 5x4 | Per-station op code |
| iss_dst | output | 5x3 | Per-station destination tag |
| iss_va | output | 5x32 | Per-station source A value |
| iss_vb | output | 5x32 | Per-station source B value |

## Verification
The hardest situations to reach are the coincidences. One is a broadcast that lands in the very cycle its consumer is dispatched. Another is a go pulse on a station that still waits on one operand. A third is a flush that collides with a dispatch. Directed cycles build each of these on purpose. After them, a long seeded random run draws tags from a three-bit space, so broadcasts, pending tags and issue pulses overlap often. Every output is compared each cycle against a bench model built from the requirements.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int NUM_RS = 5;
    localparam int TAG_W  = 3;
    localparam int DATA_W = 32;
    localparam int OP_W   = 4;
    localparam int KIND_W = $clog2(NUM_RS + 1);

    typedef enum logic [KIND_W-1:0] {
        K_ALU = 3'd0,
        K_LD  = 3'd1,
        K_ST  = 3'd2,
        K_FP1 = 3'd3,
        K_FP2 = 3'd4
    } rs_kind_e;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        tag_t  tag;
        word_t val;
    } opnd_t;

    typedef struct packed {
        logic            busy;
        logic [OP_W-1:0] op;
        tag_t            dst;
        opnd_t           a;
        opnd_t           b;
    } rs_slot_t;

    function automatic logic tag_hit(tag_t pending, logic bv, tag_t bt);
        return bv && (pending != '0) && (pending == bt);
    endfunction
endpackage

// File: rtl/rs_operand_sel.sv
module rs_operand_sel
    import rs_pkg::*;
(
    input  tag_t  tag,
    input  logic  in_buf,
    input  word_t rf_val,
    input  word_t buf_val,
    input  logic  bc_valid,
    input  tag_t  bc_tag,
    input  word_t bc_val,
    output opnd_t res
);
    always_comb begin
        if (tag == '0)
            res = '{tag: '0, val: rf_val};
        else if (in_buf)
            res = '{tag: '0, val: buf_val};
        else if (tag_hit(tag, bc_valid, bc_tag))
            res = '{tag: '0, val: bc_val};
        else
            res = '{tag: tag, val: '0};
    end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            alloc,
    input  logic [OP_W-1:0] op_in,
    input  tag_t            dst_in,
    input  opnd_t           a_in,
    input  opnd_t           b_in,
    input  logic            bc_valid,
    input  tag_t            bc_tag,
    input  word_t           bc_val,
    input  logic            go,
    output rs_slot_t        slot,
    output logic            ready
);
    assign ready = slot.busy && (slot.a.tag == '0) && (slot.b.tag == '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            slot <= '0;
        end else if (alloc) begin
            slot <= '{busy: 1'b1, op: op_in, dst: dst_in, a: a_in, b: b_in};
        end else if (slot.busy) begin
            if (go && ready) begin
                slot.busy <= 1'b0;
            end else begin
                if (tag_hit(slot.a.tag, bc_valid, bc_tag))
                    slot.a <= '{tag: '0, val: bc_val};
                if (tag_hit(slot.b.tag, bc_valid, bc_tag))
                    slot.b <= '{tag: '0, val: bc_val};
            end
        end
    end

    assert_issue_frees_R10: assert property (@(posedge clk) disable iff (rst)
        (ready && go && !flush && !alloc) |=> !slot.busy);

    assert_flush_clears_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> !slot.busy);

    assert_capture_a_R7: assert property (@(posedge clk) disable iff (rst)
        (slot.busy && !alloc && !flush && bc_valid && slot.a.tag != '0 && bc_tag == slot.a.tag)
        |=> (slot.a.tag == '0 && slot.a.val == $past(bc_val)));

    assert_capture_b_R7: assert property (@(posedge clk) disable iff (rst)
        (slot.busy && !alloc && !flush && bc_valid && slot.b.tag != '0 && bc_tag == slot.b.tag)
        |=> (slot.b.tag == '0 && slot.b.val == $past(bc_val)));

    assert_wait_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (slot.busy && !alloc && !flush && !(bc_valid && bc_tag == slot.a.tag))
        |=> $stable(slot.a.tag));
endmodule

// File: rtl/rs_array.sv
module rs_array
    import rs_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              flush,
    input  logic                              disp_valid,
    input  logic [KIND_W-1:0]                 disp_kind,
    input  logic [OP_W-1:0]                   disp_op,
    input  logic [TAG_W-1:0]                  disp_dst,
    input  logic [TAG_W-1:0]                  src_a_tag,
    input  logic                              src_a_inbuf,
    input  logic [DATA_W-1:0]                 src_a_rf,
    input  logic [DATA_W-1:0]                 src_a_buf,
    input  logic [TAG_W-1:0]                  src_b_tag,
    input  logic                              src_b_inbuf,
    input  logic [DATA_W-1:0]                 src_b_rf,
    input  logic [DATA_W-1:0]                 src_b_buf,
    input  logic                              bc_valid,
    input  logic [TAG_W-1:0]                  bc_tag,
    input  logic [DATA_W-1:0]                 bc_val,
    input  logic [NUM_RS-1:0]                 issue_go,
    output logic                              disp_stall,
    output logic [NUM_RS-1:0]                 st_busy,
    output logic [NUM_RS-1:0]                 st_ready,
    output logic [NUM_RS-1:0][OP_W-1:0]       iss_op,
    output logic [NUM_RS-1:0][TAG_W-1:0]      iss_dst,
    output logic [NUM_RS-1:0][DATA_W-1:0]     iss_va,
    output logic [NUM_RS-1:0][DATA_W-1:0]     iss_vb
);
    opnd_t                 opa, opb;
    rs_slot_t [NUM_RS-1:0] slots;
    logic     [NUM_RS-1:0] alloc_vec;
    logic                  kind_ok;

    rs_operand_sel u_sel_a (
        .tag(src_a_tag), .in_buf(src_a_inbuf), .rf_val(src_a_rf), .buf_val(src_a_buf),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val), .res(opa)
    );

    rs_operand_sel u_sel_b (
        .tag(src_b_tag), .in_buf(src_b_inbuf), .rf_val(src_b_rf), .buf_val(src_b_buf),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val), .res(opb)
    );

    assign kind_ok    = disp_kind < KIND_W'(NUM_RS);
    assign disp_stall = disp_valid && kind_ok && (|(st_busy & (NUM_RS'(1) << disp_kind)));

    for (genvar i = 0; i < NUM_RS; i++) begin : g_st
        assign alloc_vec[i] = disp_valid && !flush && (disp_kind == KIND_W'(i)) && !slots[i].busy;

        rs_entry u_entry (
            .clk(clk), .rst(rst), .flush(flush), .alloc(alloc_vec[i]),
            .op_in(disp_op), .dst_in(disp_dst), .a_in(opa), .b_in(opb),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
            .go(issue_go[i]), .slot(slots[i]), .ready(st_ready[i])
        );

        assign st_busy[i] = slots[i].busy;
        assign iss_op[i]  = slots[i].op;
        assign iss_dst[i] = slots[i].dst;
        assign iss_va[i]  = slots[i].a.val;
        assign iss_vb[i]  = slots[i].b.val;
    end

    assert_single_alloc_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alloc_vec));

    assert_stall_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        disp_stall |-> (alloc_vec == '0));

    assert_ready_implies_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (st_ready & ~st_busy) == '0);
endmodule

// File: tb/rs_array_tb.sv
module rs_array_tb;
    import rs_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1, flush = 0, dv = 0;
    logic [KIND_W-1:0] dk = 0;
    logic [OP_W-1:0] dop = 0;
    logic [TAG_W-1:0] ddst = 0, ta = 0, tb = 0, bt = 0;
    logic ra = 0, rb = 0, bv = 0;
    logic [DATA_W-1:0] fa = 0, oa = 0, fb = 0, ob = 0, bval = 0;
    logic [NUM_RS-1:0] go = 0;
    logic stall;
    logic [NUM_RS-1:0] busy, rdy;
    logic [NUM_RS-1:0][OP_W-1:0] q_op;
    logic [NUM_RS-1:0][TAG_W-1:0] q_dst;
    logic [NUM_RS-1:0][DATA_W-1:0] q_va, q_vb;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_array u_dut (
        .clk(clk), .rst(rst), .flush(flush), .disp_valid(dv), .disp_kind(dk),
        .disp_op(dop), .disp_dst(ddst),
        .src_a_tag(ta), .src_a_inbuf(ra), .src_a_rf(fa), .src_a_buf(oa),
        .src_b_tag(tb), .src_b_inbuf(rb), .src_b_rf(fb), .src_b_buf(ob),
        .bc_valid(bv), .bc_tag(bt), .bc_val(bval), .issue_go(go),
        .disp_stall(stall), .st_busy(busy), .st_ready(rdy),
        .iss_op(q_op), .iss_dst(q_dst), .iss_va(q_va), .iss_vb(q_vb)
    );

    int n_chk = 0, n_fail = 0;

    // reference model
    logic m_busy [NUM_RS];
    logic [OP_W-1:0] m_op [NUM_RS];
    logic [TAG_W-1:0] m_dst [NUM_RS], m_ta [NUM_RS], m_tb [NUM_RS];
    logic [DATA_W-1:0] m_va [NUM_RS], m_vb [NUM_RS];

    function automatic logic m_ready(int i);
        return m_busy[i] && m_ta[i] == 0 && m_tb[i] == 0;
    endfunction

    function automatic logic hit(logic [TAG_W-1:0] t);
        return bv && t != 0 && t == bt;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic resolve(input logic [TAG_W-1:0] t, input logic r, input logic [DATA_W-1:0] f,
                           input logic [DATA_W-1:0] o, output logic [TAG_W-1:0] rt, output logic [DATA_W-1:0] rv);
        if (t == 0) begin rt = 0; rv = f; end
        else if (r) begin rt = 0; rv = o; end
        else if (hit(t)) begin rt = 0; rv = bval; end
        else begin rt = t; rv = 0; end
    endtask

    task automatic model_step();
        for (int i = 0; i < NUM_RS; i++) begin
            if (rst || flush) begin
                m_busy[i] = 0; m_ta[i] = 0; m_tb[i] = 0;
            end else if (dv && dk == KIND_W'(i) && !m_busy[i]) begin
                m_busy[i] = 1; m_op[i] = dop; m_dst[i] = ddst;
                resolve(ta, ra, fa, oa, m_ta[i], m_va[i]);
                resolve(tb, rb, fb, ob, m_tb[i], m_vb[i]);
            end else if (m_busy[i]) begin
                if (go[i] && m_ready(i)) m_busy[i] = 0;
                else begin
                    if (hit(m_ta[i])) begin m_ta[i] = 0; m_va[i] = bval; end
                    if (hit(m_tb[i])) begin m_tb[i] = 0; m_vb[i] = bval; end
                end
            end
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < NUM_RS; i++) begin
            chk(busy[i] == m_busy[i], "R2 busy", 64'(busy[i]), 64'(m_busy[i]));
            chk(rdy[i] == m_ready(i), "R9 ready", 64'(rdy[i]), 64'(m_ready(i)));
            if (m_busy[i]) begin
                chk(q_op[i] == m_op[i], "R2 op", 64'(q_op[i]), 64'(m_op[i]));
                chk(q_dst[i] == m_dst[i], "R2 dst", 64'(q_dst[i]), 64'(m_dst[i]));
            end
            if (m_ready(i)) begin
                chk(q_va[i] == m_va[i], "R7 value A", 64'(q_va[i]), 64'(m_va[i]));
                chk(q_vb[i] == m_vb[i], "R7 value B", 64'(q_vb[i]), 64'(m_vb[i]));
            end
        end
    endtask

    // inputs set at negedge; one clock step; outputs checked at next negedge
    task automatic cycle();
        logic exp_stall;
        #1;
        exp_stall = dv && dk < KIND_W'(NUM_RS) && m_busy[dk];
        chk(stall == exp_stall, "R3 stall", 64'(stall), 64'(exp_stall));
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        dv = 0; bv = 0; go = 0; flush = 0; rst = 0;
    endtask

    task automatic disp(input logic [KIND_W-1:0] k, input logic [OP_W-1:0] op, input logic [TAG_W-1:0] d,
                        input logic [TAG_W-1:0] t1, input logic r1, input logic [DATA_W-1:0] f1, input logic [DATA_W-1:0] o1,
                        input logic [TAG_W-1:0] t2, input logic r2, input logic [DATA_W-1:0] f2, input logic [DATA_W-1:0] o2);
        dv = 1; dk = k; dop = op; ddst = d;
        ta = t1; ra = r1; fa = f1; oa = o1; tb = t2; rb = r2; fb = f2; ob = o2;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NUM_RS; i++) begin
            m_busy[i] = 0; m_op[i] = 0; m_dst[i] = 0; m_ta[i] = 0; m_tb[i] = 0; m_va[i] = 0; m_vb[i] = 0;
        end
        @(negedge clk); rst = 1; cycle(); cycle();
        chk(busy == 0 && rdy == 0, "R1 reset empty", 64'({busy, rdy}), 64'(0));
        idle();

        // R4 / R5: register-file and buffer values on entry
        disp(K_ALU, 4'd3, 3'd2, 3'd0, 1'b0, 32'h11, 32'hBAD, 3'd5, 1'b1, 32'hBAD, 32'h22);
        cycle(); idle();
        chk(rdy[0] == 1'b1, "R5 ready after dispatch", 64'(rdy[0]), 64'(1));
        chk(q_va[0] == 32'h11, "R4 rf value", 64'(q_va[0]), 64'h11);
        chk(q_vb[0] == 32'h22, "R5 buffer value", 64'(q_vb[0]), 64'h22);

        // R3: dispatch into busy station
        disp(K_ALU, 4'd9, 3'd7, 3'd0, 1'b0, 32'h77, 32'h0, 3'd0, 1'b0, 32'h78, 32'h0);
        cycle(); idle();
        chk(q_va[0] == 32'h11 && q_op[0] == 4'd3, "R3 contents kept", 64'(q_va[0]), 64'h11);

        // R2: invalid kind dropped
        disp(3'd6, 4'd1, 3'd1, 3'd0, 1'b0, 32'h1, 32'h0, 3'd0, 1'b0, 32'h1, 32'h0);
        cycle(); idle();
        chk(busy == 5'b00001, "R2 invalid kind dropped", 64'(busy), 64'b00001);

        // R6: pending tag waits
        disp(K_LD, 4'd5, 3'd3, 3'd4, 1'b0, 32'h0, 32'h0, 3'd0, 1'b0, 32'h7, 32'h0);
        cycle(); idle();
        chk(busy[1] && !rdy[1], "R6 waiting not ready", 64'(rdy[1]), 64'(0));

        // R10: go on not-ready has no effect
        go = 5'b00010; cycle(); idle();
        chk(busy[1] == 1'b1, "R10 go ignored while waiting", 64'(busy[1]), 64'(1));

        // R7: non-matching then matching broadcast
        bv = 1; bt = 3'd6; bval = 32'h66; cycle(); idle();
        chk(!rdy[1], "R7 non-match ignored", 64'(rdy[1]), 64'(0));
        bv = 1; bt = 3'd4; bval = 32'h44; cycle(); idle();
        chk(rdy[1] && q_va[1] == 32'h44, "R7 captured", 64'(q_va[1]), 64'h44);

        // R10: go on ready frees
        go = 5'b00010; cycle(); idle();
        chk(!busy[1], "R10 freed at issue", 64'(busy[1]), 64'(0));

        // R8: broadcast in dispatch cycle
        disp(K_FP1, 4'd2, 3'd6, 3'd3, 1'b0, 32'h0, 32'h0, 3'd0, 1'b0, 32'h1, 32'h0);
        bv = 1; bt = 3'd3; bval = 32'h99; cycle(); idle();
        chk(rdy[3] && q_va[3] == 32'h99, "R8 same-cycle capture", 64'(q_va[3]), 64'h99);

        // R11: flush overrides dispatch
        disp(K_FP2, 4'd1, 3'd1, 3'd0, 1'b0, 32'h5, 32'h0, 3'd0, 1'b0, 32'h5, 32'h0);
        flush = 1; cycle(); idle();
        chk(busy == 0, "R11 flush empties", 64'(busy), 64'(0));

        // random phase
        for (int n = 0; n < 4000; n++) begin
            dv = ($urandom % 2) == 0;
            dk = KIND_W'($urandom % 6);
            dop = OP_W'($urandom); ddst = TAG_W'($urandom);
            ta = TAG_W'($urandom); ra = ($urandom % 3) == 0; fa = $urandom; oa = $urandom;
            tb = TAG_W'($urandom); rb = ($urandom % 3) == 0; fb = $urandom; ob = $urandom;
            bv = ($urandom % 5) < 3; bt = TAG_W'($urandom); bval = $urandom;
            go = NUM_RS'($urandom);
            flush = ($urandom % 50) == 0;
            cycle();
        end
        idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule